// File: doc/BRIEF.md
# Configuration Access Request Gate

This block sits between a register-mapped host port and the link that carries configuration transactions. The host hands it one configuration read or write at a time. Each request names a bus, a device, a function, a 12-bit register offset, an access size in bytes and, for writes, the data. Before anything leaves the chip, the block decides whether the target may be reached. It checks the local bus and device numbers that the surrounding logic supplies, along with a link-down flag.

A request that passes the gate becomes one downstream strobe. The strobe carries a packed configuration address word, byte enables and lane-aligned write data. The gate then waits for the link's response. For a read it extracts the addressed byte or halfword from the returned dword. A request that fails the gate, or that has an illegal size or alignment, never reaches the link. It is completed locally with a status code.

The link transaction itself is a plain strobe/response handshake. Only one access is ever outstanding: the host-side ready stays low from acceptance until the completion pulse.

Top module: `cfgGate`

## Requirements
- R1: The downstream address word holds a set enable flag in bit 31, the request bus in bits 23:16, the device in bits 15:11 and the function in bits 10:8. Register offset bits 11:8 go in bits 27:24 and offset bits 7:2 in bits 7:2. Bits 30:28 and 1:0 are zero.
- R2: A request whose bus and device both equal the local bus and local device numbers completes locally with status 1 (device not found) and raises no downstream strobe.
- R3: While the link-down input is high, every request completes locally with status 1 and raises no downstream strobe.
- R4: On the local bus, the only reachable device is device 1 when the local device number is 0, and device 0 otherwise. Any other device on that bus completes locally with status 1.
- R5: A locally rejected read (status 1) returns 0xFFFFFFFF as completion data. A rejected write returns data 0 and is dropped.
- R6: A successful read of size 1 or 2 returns the response dword shifted right by 8 times (offset mod 4) and masked to 8 or 16 bits. A size-4 read returns the dword unchanged. A successful write completes with status 0 and data 0.
- R7: Byte enables are 1 shifted left by (offset mod 4) for size 1, 3 shifted left by (offset mod 4) for size 2, and all four lanes for size 4. Sub-word write data is shifted left by 8 times (offset mod 4).
- R8: A size other than 1, 2 or 4 completes locally with status 2 (bad register number) and no downstream strobe.
- R9: A 2-byte access at offset mod 4 equal to 3 completes locally with status 3 (misaligned) and no downstream strobe.
- R10: After a request is accepted, ready stays low until the single-cycle completion pulse. Exactly one downstream strobe and one completion result per accepted request.
- R11: The reachability checks of R2 to R4 take priority over the size and alignment checks of R8 and R9.
- R12: Timing: the downstream strobe rises in the second cycle after acceptance. A locally completed request pulses its completion in the second cycle after acceptance. A forwarded request pulses its completion in the cycle after the response is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Gate idle, request accepted when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqReg | input | 12 | Register byte offset |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, right-aligned |
| localBus | input | 8 | Bus number of this port |
| localDev | input | 5 | Device number of this port |
| linkDown | input | 1 | Link not trained |
| dnValid | output | 1 | Downstream request strobe, one cycle |
| dnWrite | output | 1 | Downstream direction |
| dnAddr | output | 32 | Packed configuration address |
| dnByteEn | output | 4 | Byte lane enables |
| dnWdata | output | 32 | Lane-aligned write data |
| dnRespValid | input | 1 | Link response present |
| dnRdata | input | 32 | Link read dword |
| cplValid | output | 1 | Completion pulse to host |
| cplStatus | output | 2 | 0 ok, 1 not found, 2 bad size, 3 misaligned |
| cplRdata | output | 32 | Completion read data |

## Verification
The overlap of interest is a new host request arriving while the previous access is still in its check or issue cycles. In one case the bench deliberately keeps reqValid asserted, with fresh-looking fields, through those cycles. A per-clock monitor counts downstream strobes and completion pulses against the number of requests the model expects. The held-off request must neither produce a second strobe nor disturb the address of the first. A second overlap is a reachability failure together with an illegal size in the same request. There the status code shows which check wins.

// File: rtl/cfgGatePkg.sv
package cfgGatePkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 12;
  localparam int SIZE_W = 3;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOTFOUND = 2'd1,
    ST_BADREG   = 2'd2,
    ST_MISALIGN = 2'd3
  } cfgStatus_t;

  typedef struct packed {
    logic capture;
    logic issue;
    logic takeResp;
    logic takeLocal;
  } cfgStrobe_t;
endpackage

// File: rtl/cfgGateFilter.sv
module cfgGateFilter
  import cfgGatePkg::*;
(
  input  logic [BUS_W-1:0]  tgtBus,
  input  logic [DEV_W-1:0]  tgtDev,
  input  logic [SIZE_W-1:0] tgtSize,
  input  logic [OFF_W-1:0]  tgtOff,
  input  logic [BUS_W-1:0]  localBus,
  input  logic [DEV_W-1:0]  localDev,
  input  logic              linkDown,
  output cfgStatus_t        verdict
);
  logic onLocalBus;
  logic isSelf;
  logic notNeighbour;
  logic unreachable;
  logic sizeLegal;

  always_comb begin
    onLocalBus   = (tgtBus == localBus);
    isSelf       = onLocalBus && (tgtDev == localDev);
    notNeighbour = onLocalBus &&
                   (((localDev == '0) && (tgtDev != DEV_W'(1))) ||
                    ((localDev != '0) && (tgtDev != '0)));
    unreachable  = isSelf || linkDown || notNeighbour;
    sizeLegal    = (tgtSize == SIZE_W'(1)) || (tgtSize == SIZE_W'(2)) ||
                   (tgtSize == SIZE_W'(4));
    if (unreachable)
      verdict = ST_NOTFOUND;
    else if (!sizeLegal)
      verdict = ST_BADREG;
    else if ((tgtSize == SIZE_W'(2)) && (tgtOff == OFF_W'(LANES - 1)))
      verdict = ST_MISALIGN;
    else
      verdict = ST_OK;
  end
endmodule

// File: rtl/cfgGateCtrl.sv
module cfgGateCtrl
  import cfgGatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       dnRespValid,
  input  cfgStatus_t verdict,
  output logic       reqReady,
  output logic       cplValid,
  output cfgStrobe_t strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_ISSUE, S_WAIT, S_DONE
  } ctrlState_t;

  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (reqValid) stateNext = S_CHECK;
      S_CHECK: stateNext = (verdict == ST_OK) ? S_ISSUE : S_DONE;
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT:  if (dnRespValid) stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady       = (state == S_IDLE);
    cplValid       = (state == S_DONE);
    strb.capture   = (state == S_IDLE) && reqValid;
    strb.issue     = (state == S_ISSUE);
    strb.takeResp  = (state == S_WAIT) && dnRespValid;
    strb.takeLocal = (state == S_CHECK) && (verdict != ST_OK);
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> !reqReady); // R10
  AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rstN) cplValid |=> (!cplValid && reqReady)); // R10
endmodule

// File: rtl/cfgGateDp.sv
module cfgGateDp
  import cfgGatePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  localBus,
  input  logic [DEV_W-1:0]  localDev,
  input  logic              linkDown,
  input  logic [DATA_W-1:0] dnRdata,
  output cfgStatus_t        verdict,
  output logic              dnValid,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnAddr,
  output logic [LANES-1:0]  dnByteEn,
  output logic [DATA_W-1:0] dnWdata,
  output logic [1:0]        cplStatus,
  output logic [DATA_W-1:0] cplRdata
);
  localparam int SHIFT_W = OFF_W + 3;

  logic              rWrite;
  logic [BUS_W-1:0]  rBus;
  logic [DEV_W-1:0]  rDev;
  logic [FUNC_W-1:0] rFunc;
  logic [REG_W-1:0]  rReg;
  logic [SIZE_W-1:0] rSize;
  logic [DATA_W-1:0] rWdata;
  logic [OFF_W-1:0]  laneOff;
  logic [SHIFT_W-1:0] bitShift;
  logic [DATA_W-1:0] rdShifted;
  logic [DATA_W-1:0] rdExtract;
  cfgStatus_t        statusQ;
  logic [DATA_W-1:0] cplDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rWrite <= 1'b0;
      rBus   <= '0;
      rDev   <= '0;
      rFunc  <= '0;
      rReg   <= '0;
      rSize  <= '0;
      rWdata <= '0;
    end else if (strb.capture) begin
      rWrite <= reqWrite;
      rBus   <= reqBus;
      rDev   <= reqDev;
      rFunc  <= reqFunc;
      rReg   <= reqReg;
      rSize  <= reqSize;
      rWdata <= reqWdata;
    end
  end

  assign laneOff  = rReg[OFF_W-1:0];
  assign bitShift = {laneOff, 3'b000};

  cfgGateFilter uFilter (
    .tgtBus   (rBus),
    .tgtDev   (rDev),
    .tgtSize  (rSize),
    .tgtOff   (laneOff),
    .localBus (localBus),
    .localDev (localDev),
    .linkDown (linkDown),
    .verdict  (verdict)
  );

  always_comb begin
    dnValid = strb.issue;
    dnWrite = rWrite;
    dnAddr  = {1'b1, 3'b000, rReg[11:8], rBus, rDev, rFunc, rReg[7:2], 2'b00};
    case (rSize)
      SIZE_W'(1): begin
        dnByteEn = LANES'(1) << laneOff;
        dnWdata  = rWdata << bitShift;
      end
      SIZE_W'(2): begin
        dnByteEn = LANES'(3) << laneOff;
        dnWdata  = rWdata << bitShift;
      end
      default: begin
        dnByteEn = '1;
        dnWdata  = rWdata;
      end
    endcase
  end

  always_comb begin
    rdShifted = dnRdata >> bitShift;
    case (rSize)
      SIZE_W'(1): rdExtract = rdShifted & DATA_W'(32'h0000_00ff);
      SIZE_W'(2): rdExtract = rdShifted & DATA_W'(32'h0000_ffff);
      default:    rdExtract = dnRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= ST_OK;
      cplDataQ <= '0;
    end else if (strb.takeResp) begin
      statusQ  <= ST_OK;
      cplDataQ <= rWrite ? '0 : rdExtract;
    end else if (strb.takeLocal) begin
      statusQ  <= verdict;
      cplDataQ <= (!rWrite && (verdict == ST_NOTFOUND)) ? '1 : '0;
    end
  end

  assign cplStatus = statusQ;
  assign cplRdata  = cplDataQ;

  AST_ADDR_TARGET: assert property (@(posedge clk) disable iff (!rstN) dnValid |-> (dnAddr[23:16] == $past(reqBus, 2) && dnAddr[15:11] == $past(reqDev, 2))); // R1
  AST_NO_SELF: assert property (@(posedge clk) disable iff (!rstN) dnValid |-> !(dnAddr[23:16] == $past(localBus) && dnAddr[15:11] == $past(localDev))); // R2
  AST_LINK_UP: assert property (@(posedge clk) disable iff (!rstN) dnValid |-> !$past(linkDown)); // R3
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN) dnValid |-> ($countones(dnByteEn) == 1 || $countones(dnByteEn) == 2 || $countones(dnByteEn) == 4)); // R7
endmodule

// File: rtl/cfgGate.sv
module cfgGate
  import cfgGatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [7:0]  reqBus,
  input  logic [4:0]  reqDev,
  input  logic [2:0]  reqFunc,
  input  logic [11:0] reqReg,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  logic [7:0]  localBus,
  input  logic [4:0]  localDev,
  input  logic        linkDown,
  output logic        dnValid,
  output logic        dnWrite,
  output logic [31:0] dnAddr,
  output logic [3:0]  dnByteEn,
  output logic [31:0] dnWdata,
  input  logic        dnRespValid,
  input  logic [31:0] dnRdata,
  output logic        cplValid,
  output logic [1:0]  cplStatus,
  output logic [31:0] cplRdata
);
  cfgStrobe_t strb;
  cfgStatus_t verdict;

  cfgGateCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .dnRespValid (dnRespValid),
    .verdict     (verdict),
    .reqReady    (reqReady),
    .cplValid    (cplValid),
    .strb        (strb)
  );

  cfgGateDp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .reqBus    (reqBus),
    .reqDev    (reqDev),
    .reqFunc   (reqFunc),
    .reqReg    (reqReg),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .localBus  (localBus),
    .localDev  (localDev),
    .linkDown  (linkDown),
    .dnRdata   (dnRdata),
    .verdict   (verdict),
    .dnValid   (dnValid),
    .dnWrite   (dnWrite),
    .dnAddr    (dnAddr),
    .dnByteEn  (dnByteEn),
    .dnWdata   (dnWdata),
    .cplStatus (cplStatus),
    .cplRdata  (cplRdata)
  );
endmodule

// File: tb/sim_cfgGate.sv
module sim_cfgGate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [11:0] reqReg = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [7:0]  localBus = '0;
  logic [4:0]  localDev = '0;
  logic        linkDown = 1'b0;
  logic        dnValid;
  logic        dnWrite;
  logic [31:0] dnAddr;
  logic [3:0]  dnByteEn;
  logic [31:0] dnWdata;
  logic        dnRespValid = 1'b0;
  logic [31:0] dnRdata = '0;
  logic        cplValid;
  logic [1:0]  cplStatus;
  logic [31:0] cplRdata;

  int nChecks = 0;
  int nFail = 0;
  int dnSeen = 0;
  int cplSeen = 0;
  int expDn = 0;
  int expCpl = 0;

  always #10 clk = ~clk;

  cfgGate u0 (.*);

  always @(negedge clk) begin
    if (rstN) begin
      if (dnValid) dnSeen++;
      if (cplValid) cplSeen++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int refVerdict(input logic [7:0] b, input logic [4:0] d, input logic [11:0] r, input logic [2:0] s);
    bit blocked;
    blocked = linkDown || (b == localBus && d == localDev);
    if (b == localBus) begin
      if (localDev == 0 && d != 1) blocked = 1;
      if (localDev != 0 && d != 0) blocked = 1;
    end
    if (blocked) return 1;
    if (!(s == 1 || s == 2 || s == 4)) return 2;
    if (s == 2 && r[1:0] == 2'd3) return 3;
    return 0;
  endfunction

  task automatic runReq(input bit wr, input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [11:0] r, input logic [2:0] s, input logic [31:0] wd,
                        input logic [31:0] rd, input int dly, input bit holdValid, input string tag);
    int st;
    int o;
    logic [31:0] eAddr, eBe, eWd, eData;
    st = refVerdict(b, d, r, s);
    o = int'(r[1:0]);
    eAddr = 32'h8000_0000 | (32'(r[11:8]) << 24) | (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | (32'(r) & 32'hFC);
    eBe = (s == 1) ? (32'h1 << o) : (s == 2) ? (32'h3 << o) : 32'hF;
    eWd = (s == 4) ? wd : (wd << (8 * o));
    @(negedge clk);
    chk(tag, 32'(reqReady), 1, "ready before request (R10)");
    reqWrite = wr; reqBus = b; reqDev = d; reqFunc = f; reqReg = r; reqSize = s; reqWdata = wd;
    reqValid = 1'b1;
    expCpl++;
    @(negedge clk);
    if (!holdValid) reqValid = 1'b0;
    else begin
      reqBus = b + 8'd1; reqDev = d + 5'd1; reqWdata = ~wd;
    end
    chk(tag, 32'(reqReady), 0, "ready low while busy (R10)");
    chk(tag, 32'(dnValid), 0, "no strobe in check cycle (R12)");
    @(negedge clk);
    reqValid = 1'b0;
    if (st == 0) begin
      expDn++;
      chk(tag, 32'(dnValid), 1, "strobe second cycle after accept (R12)");
      chk(tag, dnAddr, eAddr, "address word (R1)");
      chk(tag, 32'(dnWrite), 32'(wr), "direction");
      chk(tag, 32'(dnByteEn), eBe, "byte enables (R7)");
      if (wr) chk(tag, dnWdata, eWd, "lane data (R7)");
      repeat (dly) @(negedge clk);
      chk(tag, 32'(cplValid), 0, "no completion before response (R12)");
      dnRdata = rd;
      dnRespValid = 1'b1;
      @(negedge clk);
      dnRespValid = 1'b0;
      if (wr) eData = 0;
      else if (s == 1) eData = (rd >> (8 * o)) & 32'hFF;
      else if (s == 2) eData = (rd >> (8 * o)) & 32'hFFFF;
      else eData = rd;
      chk(tag, 32'(cplValid), 1, "completion after response (R12)");
      chk(tag, 32'(cplStatus), 0, "status ok (R6)");
      chk(tag, cplRdata, eData, "completion data (R6)");
    end else begin
      eData = (!wr && st == 1) ? 32'hFFFF_FFFF : 32'h0;
      chk(tag, 32'(dnValid), 0, "no strobe when filtered");
      chk(tag, 32'(cplValid), 1, "local completion second cycle (R12)");
      chk(tag, 32'(cplStatus), 32'(st), "local status");
      chk(tag, cplRdata, eData, "local data (R5)");
    end
    @(negedge clk);
    chk(tag, 32'(cplValid), 0, "completion is one cycle (R10)");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", 32'(reqReady), 1, "reset ready");
    chk("R10", 32'(dnValid), 0, "reset strobe");
    chk("R10", 32'(cplValid), 0, "reset completion");

    localBus = 8'd0; localDev = 5'd0; linkDown = 1'b0;
    runReq(0, 8'd2, 5'd7, 3'd5, 12'hA6C, 3'd4, 0, 32'h11223344, 1, 0, "R1");
    runReq(0, 8'd2, 5'd3, 3'd0, 12'h012, 3'd1, 0, 32'hAABBCCDD, 2, 0, "R6");
    runReq(0, 8'd2, 5'd3, 3'd0, 12'h022, 3'd2, 0, 32'hAABBCCDD, 1, 0, "R6");
    runReq(1, 8'd4, 5'd9, 3'd2, 12'h041, 3'd1, 32'h0000005A, 0, 1, 0, "R7");
    runReq(1, 8'd4, 5'd9, 3'd2, 12'h042, 3'd2, 32'h00001234, 0, 3, 0, "R7");
    runReq(1, 8'd4, 5'd9, 3'd7, 12'hF43, 3'd4, 32'hCAFEF00D, 0, 1, 0, "R7");
    runReq(0, 8'd3, 5'd1, 3'd1, 12'h301, 3'd2, 0, 32'h89ABCDEF, 1, 0, "R9");
    runReq(0, 8'd0, 5'd1, 3'd0, 12'h000, 3'd4, 0, 32'h12345678, 1, 0, "R4");
    runReq(0, 8'd0, 5'd2, 3'd0, 12'h000, 3'd4, 0, 0, 1, 0, "R4");
    runReq(0, 8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 0, 0, 1, 0, "R2");

    localBus = 8'd9; localDev = 5'd3;
    runReq(0, 8'd9, 5'd3, 3'd1, 12'h010, 3'd4, 0, 0, 1, 0, "R2");
    runReq(1, 8'd9, 5'd3, 3'd1, 12'h010, 3'd4, 32'h1, 0, 1, 0, "R5");
    runReq(0, 8'd9, 5'd0, 3'd0, 12'h008, 3'd1, 0, 32'h00000077, 1, 0, "R4");
    runReq(0, 8'd9, 5'd1, 3'd0, 12'h008, 3'd4, 0, 0, 1, 0, "R4");

    linkDown = 1'b1;
    runReq(0, 8'd2, 5'd3, 3'd0, 12'h000, 3'd4, 0, 0, 1, 0, "R3");
    runReq(1, 8'd2, 5'd3, 3'd0, 12'h000, 3'd4, 32'hDEAD, 0, 1, 0, "R3");
    linkDown = 1'b0;

    runReq(0, 8'd2, 5'd3, 3'd0, 12'h000, 3'd3, 0, 0, 1, 0, "R8");
    runReq(1, 8'd2, 5'd3, 3'd0, 12'h000, 3'd0, 32'h5, 0, 1, 0, "R8");
    runReq(0, 8'd2, 5'd3, 3'd0, 12'h003, 3'd2, 0, 0, 1, 0, "R9");
    runReq(0, 8'd9, 5'd5, 3'd0, 12'h003, 3'd3, 0, 0, 1, 0, "R11");
    runReq(0, 8'd9, 5'd3, 3'd0, 12'h003, 3'd2, 0, 0, 1, 0, "R11");

    runReq(0, 8'd6, 5'd2, 3'd3, 12'h1F8, 3'd4, 0, 32'h0BADBEEF, 2, 1, "R10");
    runReq(1, 8'd6, 5'd2, 3'd3, 12'h1FA, 3'd2, 32'h0000ABCD, 0, 1, 1, "R10");

    repeat (3) @(negedge clk);
    chk("R10", dnSeen, expDn, "downstream strobe count");
    chk("R10", cplSeen, expCpl, "completion count");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule